// File: doc/BRIEF.md
# Sixteen-Bit ALU with Excess Word

This block is the arithmetic and logic unit of a small 16-bit processor core. It takes an operation code, the two operand values (the destination operand `b` and the source operand `a`) and the present contents of the excess word. The excess word is a dedicated register that holds carries, borrows, the upper half of a product, the fractional part of a quotient or the bits shifted out of a word. The block returns the value for the destination, whether the destination is written, the next excess word with its write enable, a skip request for the conditional tests, and the cycle cost of the operation.

The block fetches no operands and writes no registers itself. The surrounding sequencer presents one operation per `opValid` cycle. One clock later it finds every output registered and applies the write enables. While `opValid` is low the outputs read as zero on the following cycle.

Top module: `alu_ex`

## Requirements
- R1: Opcode 0x02 (add) gives b + a modulo 2^16. The excess word is written with 0x0001 when the true sum exceeds 0xFFFF and with 0x0000 otherwise. Cost is 2.
- R2: Opcode 0x03 (subtract) gives b − a modulo 2^16. The excess word is written with 0xFFFF when a > b and with 0x0000 otherwise. Cost is 2.
- R3: Opcodes 0x04 (unsigned) and 0x05 (signed) multiply. The low half of the 32-bit product goes to the result and the high half to the excess word. Cost is 2.
- R4: Opcodes 0x06 (unsigned) and 0x07 (two's complement, truncating toward zero) divide. The result is b / a. The excess word is the low 16 bits of (b·2^16) / a. When a is zero, both the result and the excess word are 0. Cost is 3.
- R5: Opcodes 0x08 (unsigned) and 0x09 (signed, remainder takes the sign of b) give b mod a, or 0 when a is zero. The excess word is not written. Cost is 3.
- R6: Opcodes 0x1A and 0x1B take the full incoming excess word as carry-in. 0x1A computes b + a + excess and flags the result as for R1. 0x1B computes b − a + excess and writes 0xFFFF only when that value is negative, 0x0000 otherwise. Cost is 3.
- R7: Opcodes 0x0A, 0x0B and 0x0C give bitwise AND, OR and XOR. The excess word is not written. Cost is 1.
- R8: Opcode 0x0F shifts left: the result is the low half and the excess word the high half of b·2^a. Opcode 0x0D is a logical right shift and 0x0E an arithmetic right shift. For both right shifts the result is b shifted by a, and the excess word is the low half of (b·2^16) shifted by a. Any shift amount from 0 to 0xFFFF is legal; large amounts give zero or sign fill. Cost is 2.
- R9: Opcodes 0x10–0x17 are the tests: any-bit-common, no-bit-common, equal, not equal, unsigned greater, signed greater, unsigned less and signed less. A test writes neither the result nor the excess word. A passing test costs 2 with no skip. A failing test requests a skip and costs 3.
- R10: Any other opcode passes b through to the result with the result written, leaves the excess word unwritten, and costs 1.
- R11: All outputs appear exactly one clock after the `opValid` cycle. In a cycle following `opValid` low, `resValid`, both write enables, `skipReq`, `cycleCost` and both value outputs are 0.
- R12: While `rstN` is low, all outputs are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 5 | Operation code |
| bVal | input | 16 | Destination operand value |
| aVal | input | 16 | Source operand value |
| exIn | input | 16 | Present excess word |
| resValid | output | 1 | Outputs carry an operation result |
| resOut | output | 16 | Value for the destination |
| resWe | output | 1 | Destination is to be written |
| exOut | output | 16 | Next excess word |
| exWe | output | 1 | Excess word is to be written |
| skipReq | output | 1 | A test failed; skip the next instruction |
| cycleCost | output | 3 | Cycles the operation costs |

## Verification
The hardest cases to reach are the edges of the excess word. These are the signed quotient's fraction for a negative dividend, the right shifts by 16 or more where only the excess half still carries data, and the carry-in variants where the whole incoming excess word (not one bit) decides the flag. The directed tasks set `exIn` and the operands to values that land on those edges, such as 0xFFFF plus a carry of 1, and 0x8001 shifted by exactly 16 or by 20. Each division form is also given a zero divisor, so that the guarded path is compared against the normal quotient path in neighbouring operations.

// File: rtl/alu_ex_pkg.sv
`timescale 1ns/1ps
package alu_ex_pkg;
  localparam int OP_W  = 5;
  localparam int CYC_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 5'h02, OP_SUBTRACT = 5'h03,
    OP_MULU    = 5'h04, OP_MULS     = 5'h05,
    OP_DIVU    = 5'h06, OP_DIVS     = 5'h07,
    OP_REMU    = 5'h08, OP_REMS     = 5'h09,
    OP_AND     = 5'h0A, OP_OR       = 5'h0B, OP_XOR = 5'h0C,
    OP_SRL     = 5'h0D, OP_SRA      = 5'h0E, OP_SLL = 5'h0F,
    OP_T_ANY   = 5'h10, OP_T_NONE   = 5'h11,
    OP_T_EQ    = 5'h12, OP_T_NE     = 5'h13,
    OP_T_GTU   = 5'h14, OP_T_GTS    = 5'h15,
    OP_T_LTU   = 5'h16, OP_T_LTS    = 5'h17,
    OP_ADDC    = 5'h1A, OP_SUBC     = 5'h1B
  } op_e;

  typedef enum logic [2:0] {
    U_PASS, U_ADD, U_MUL, U_DIV, U_REM, U_LOGIC, U_SHIFT, U_TEST
  } unit_e;

  typedef struct packed {
    unit_e            unit;
    logic             signedMode;
    logic             subtract;
    logic             useCarry;
    logic [2:0]       variant;
    logic             resWe;
    logic             exWe;
    logic [CYC_W-1:0] baseCost;
  } strobe_t;
endpackage

// File: rtl/alu_ex_ctrl.sv
`timescale 1ns/1ps
module alu_ex_ctrl
  import alu_ex_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output strobe_t         strobes
);
  always_comb begin
    strobes            = '0;
    strobes.unit       = U_PASS;
    strobes.resWe      = 1'b1;
    strobes.baseCost   = 3'd1;
    case (opCode)
      OP_ADD, OP_SUBTRACT, OP_ADDC, OP_SUBC: begin
        strobes.unit     = U_ADD;
        strobes.subtract = (opCode == OP_SUBTRACT) || (opCode == OP_SUBC);
        strobes.useCarry = (opCode == OP_ADDC) || (opCode == OP_SUBC);
        strobes.exWe     = 1'b1;
        strobes.baseCost = strobes.useCarry ? 3'd3 : 3'd2;
      end
      OP_MULU, OP_MULS: begin
        strobes.unit       = U_MUL;
        strobes.signedMode = opCode[0];
        strobes.exWe       = 1'b1;
        strobes.baseCost   = 3'd2;
      end
      OP_DIVU, OP_DIVS: begin
        strobes.unit       = U_DIV;
        strobes.signedMode = opCode[0];
        strobes.exWe       = 1'b1;
        strobes.baseCost   = 3'd3;
      end
      OP_REMU, OP_REMS: begin
        strobes.unit       = U_REM;
        strobes.signedMode = opCode[0];
        strobes.baseCost   = 3'd3;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.unit    = U_LOGIC;
        strobes.variant = 3'(opCode - OP_AND);
      end
      OP_SRL, OP_SRA, OP_SLL: begin
        strobes.unit     = U_SHIFT;
        strobes.variant  = 3'(opCode - OP_SRL);
        strobes.exWe     = 1'b1;
        strobes.baseCost = 3'd2;
      end
      OP_T_ANY, OP_T_NONE, OP_T_EQ, OP_T_NE,
      OP_T_GTU, OP_T_GTS, OP_T_LTU, OP_T_LTS: begin
        strobes.unit     = U_TEST;
        strobes.variant  = opCode[2:0];
        strobes.resWe    = 1'b0;
        strobes.baseCost = 3'd2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_ex_dp.sv
`timescale 1ns/1ps
module alu_ex_dp
  import alu_ex_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] bVal,
  input  logic [WIDTH-1:0] aVal,
  input  logic [WIDTH-1:0] exIn,
  output logic             resValid,
  output logic [WIDTH-1:0] resOut,
  output logic             resWe,
  output logic [WIDTH-1:0] exOut,
  output logic             exWe,
  output logic             skipReq,
  output logic [CYC_W-1:0] cycleCost
);
  localparam int W2 = 2 * WIDTH;
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ZERO = {WIDTH{1'b0}};

  // add / subtract with optional full-word carry-in
  logic [WIDTH+1:0] carryTerm, addWide;
  logic [WIDTH-1:0] addEx;
  assign carryTerm = strobes.useCarry ? {2'b00, exIn} : '0;
  always_comb begin
    if (strobes.subtract) begin
      addWide = {2'b00, bVal} - {2'b00, aVal} + carryTerm;
      addEx   = addWide[WIDTH+1] ? ONES : ZERO;
    end else begin
      addWide = {2'b00, bVal} + {2'b00, aVal} + carryTerm;
      addEx   = (addWide[WIDTH+1:WIDTH] != 2'b00) ? ONE : ZERO;
    end
  end

  // multiply
  logic signed [W2+1:0] mulS;
  logic [W2-1:0] mulU, mulP;
  assign mulS = $signed({bVal[WIDTH-1], bVal}) * $signed({aVal[WIDTH-1], aVal});
  assign mulU = {{WIDTH{1'b0}}, bVal} * {{WIDTH{1'b0}}, aVal};
  assign mulP = strobes.signedMode ? mulS[W2-1:0] : mulU;

  // divide / remainder, divisor guarded against zero
  logic aZero;
  logic [WIDTH-1:0] dvs;
  logic [W2-1:0] fracU;
  logic signed [W2+1:0] bSx, dSx, numSx, quoSx, fracSx, remSx;
  assign aZero  = (aVal == ZERO);
  assign dvs    = aZero ? ONE : aVal;
  assign fracU  = {bVal, ZERO} / {ZERO, dvs};
  assign bSx    = {{(WIDTH+2){bVal[WIDTH-1]}}, bVal};
  assign dSx    = {{(WIDTH+2){dvs[WIDTH-1]}}, dvs};
  assign numSx  = bSx <<< WIDTH;
  assign quoSx  = bSx / dSx;
  assign fracSx = numSx / dSx;
  assign remSx  = bSx % dSx;

  // shifts: one double-width shift gives both halves
  logic [W2-1:0] srlCat, sllCat;
  logic signed [W2-1:0] sraCat;
  assign srlCat = {bVal, ZERO} >> aVal;
  assign sraCat = $signed({bVal, ZERO}) >>> aVal;
  assign sllCat = {ZERO, bVal} << aVal;

  // tests
  logic testPass;
  always_comb begin
    case (strobes.variant)
      3'd0:    testPass = (bVal & aVal) != ZERO;
      3'd1:    testPass = (bVal & aVal) == ZERO;
      3'd2:    testPass = bVal == aVal;
      3'd3:    testPass = bVal != aVal;
      3'd4:    testPass = bVal > aVal;
      3'd5:    testPass = $signed(bVal) > $signed(aVal);
      3'd6:    testPass = bVal < aVal;
      default: testPass = $signed(bVal) < $signed(aVal);
    endcase
  end

  logic [WIDTH-1:0] nextRes, nextEx;
  logic nextSkip;
  always_comb begin
    nextRes = bVal;
    nextEx  = ZERO;
    case (strobes.unit)
      U_ADD: begin nextRes = addWide[WIDTH-1:0]; nextEx = addEx; end
      U_MUL: begin nextRes = mulP[WIDTH-1:0]; nextEx = mulP[W2-1:WIDTH]; end
      U_DIV: begin
        if (aZero) begin
          nextRes = ZERO; nextEx = ZERO;
        end else if (strobes.signedMode) begin
          nextRes = quoSx[WIDTH-1:0]; nextEx = fracSx[WIDTH-1:0];
        end else begin
          nextRes = bVal / dvs; nextEx = fracU[WIDTH-1:0];
        end
      end
      U_REM: begin
        if (aZero)                   nextRes = ZERO;
        else if (strobes.signedMode) nextRes = remSx[WIDTH-1:0];
        else                         nextRes = bVal % dvs;
      end
      U_LOGIC: begin
        case (strobes.variant)
          3'd0:    nextRes = bVal & aVal;
          3'd1:    nextRes = bVal | aVal;
          default: nextRes = bVal ^ aVal;
        endcase
      end
      U_SHIFT: begin
        case (strobes.variant)
          3'd0:    begin nextRes = srlCat[W2-1:WIDTH]; nextEx = srlCat[WIDTH-1:0]; end
          3'd1:    begin nextRes = sraCat[W2-1:WIDTH]; nextEx = sraCat[WIDTH-1:0]; end
          default: begin nextRes = sllCat[WIDTH-1:0];  nextEx = sllCat[W2-1:WIDTH]; end
        endcase
      end
      default: ;
    endcase
  end
  assign nextSkip = (strobes.unit == U_TEST) && !testPass;

  always_ff @(posedge clk) begin
    if (!rstN || !opValid) begin
      resValid  <= 1'b0;
      resOut    <= ZERO;
      resWe     <= 1'b0;
      exOut     <= ZERO;
      exWe      <= 1'b0;
      skipReq   <= 1'b0;
      cycleCost <= '0;
    end else begin
      resValid  <= 1'b1;
      resOut    <= strobes.resWe ? nextRes : ZERO;
      resWe     <= strobes.resWe;
      exOut     <= strobes.exWe ? nextEx : ZERO;
      exWe      <= strobes.exWe;
      skipReq   <= nextSkip;
      cycleCost <= strobes.baseCost + {{(CYC_W-1){1'b0}}, nextSkip};
    end
  end
endmodule

// File: rtl/alu_ex.sv
`timescale 1ns/1ps
module alu_ex
  import alu_ex_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [WIDTH-1:0] bVal,
  input  logic [WIDTH-1:0] aVal,
  input  logic [WIDTH-1:0] exIn,
  output logic             resValid,
  output logic [WIDTH-1:0] resOut,
  output logic             resWe,
  output logic [WIDTH-1:0] exOut,
  output logic             exWe,
  output logic             skipReq,
  output logic [CYC_W-1:0] cycleCost
);
  strobe_t strobes;

  alu_ex_ctrl u_ctrl (
    .opCode  (opCode),
    .strobes (strobes)
  );

  alu_ex_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opValid   (opValid),
    .strobes   (strobes),
    .bVal      (bVal),
    .aVal      (aVal),
    .exIn      (exIn),
    .resValid  (resValid),
    .resOut    (resOut),
    .resWe     (resWe),
    .exOut     (exOut),
    .exWe      (exWe),
    .skipReq   (skipReq),
    .cycleCost (cycleCost)
  );
endmodule

// File: rtl/alu_ex_sva.sv
`timescale 1ns/1ps
module alu_ex_sva
  import alu_ex_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             opValid,
  input logic [OP_W-1:0]  opCode,
  input logic [WIDTH-1:0] aVal,
  input logic             resValid,
  input logic [WIDTH-1:0] resOut,
  input logic             resWe,
  input logic [WIDTH-1:0] exOut,
  input logic             exWe,
  input logic             skipReq,
  input logic [CYC_W-1:0] cycleCost
);
  // R11
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> resValid);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!resValid && !resWe && !exWe && !skipReq && cycleCost == '0));
  // R1
  add_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_ADD) |=> (exWe && exOut <= 1 && cycleCost == 3'd2));
  // R2
  borrow_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_SUBTRACT) |=> (exWe && (exOut == '0 || exOut == '1)));
  // R4
  div_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == OP_DIVU || opCode == OP_DIVS) && aVal == '0)
      |=> (resOut == '0 && exOut == '0 && cycleCost == 3'd3));
  // R9
  skip_cost_chk: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> (resValid && !resWe && !exWe && cycleCost == 3'd3));
  // R12
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!resValid && !skipReq && cycleCost == '0) || !$past(!rstN));
endmodule

bind alu_ex alu_ex_sva #(.WIDTH(WIDTH)) u_sva (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .aVal(aVal),
  .resValid(resValid), .resOut(resOut), .resWe(resWe), .exOut(exOut),
  .exWe(exWe), .skipReq(skipReq), .cycleCost(cycleCost)
);

// File: tb/alu_ex_bench.sv
`timescale 1ns/1ps
module alu_ex_bench;
  import alu_ex_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [15:0] bVal = '0, aVal = '0, exIn = '0;
  logic resValid, resWe, exWe, skipReq;
  logic [15:0] resOut, exOut;
  logic [2:0] cycleCost;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alu_ex u_alu_ex (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .bVal(bVal), .aVal(aVal), .exIn(exIn),
    .resValid(resValid), .resOut(resOut), .resWe(resWe),
    .exOut(exOut), .exWe(exWe), .skipReq(skipReq), .cycleCost(cycleCost)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, let one rising edge pass, sample on the next falling edge
  task automatic runOp(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                       input logic [15:0] ex);
    @(negedge clk);
    opValid = 1'b1; opCode = op; bVal = b; aVal = a; exIn = ex;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic expectOp(input string tag, input logic [15:0] res, input logic rWe,
                          input logic [15:0] ex, input logic eWe, input logic skip,
                          input logic [2:0] cost);
    chk({tag, " valid"}, 32'(resValid), 32'd1);
    if (rWe) chk({tag, " res"}, 32'(resOut), 32'(res));
    chk({tag, " resWe"}, 32'(resWe), 32'(rWe));
    chk({tag, " exWe"}, 32'(exWe), 32'(eWe));
    if (eWe) chk({tag, " ex"}, 32'(exOut), 32'(ex));
    chk({tag, " skip"}, 32'(skipReq), 32'(skip));
    chk({tag, " cost"}, 32'(cycleCost), 32'(cost));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R12 valid in reset", 32'(resValid), 0);
    chk("R12 cost in reset", 32'(cycleCost), 0);
    chk("R12 res in reset", 32'(resOut), 0);
  endtask

  task automatic testAddSub();
    runOp(5'h02, 16'hFFFF, 16'h0002, 16'h0); expectOp("R1 add wrap", 16'h0001, 1, 16'h0001, 1, 0, 2);
    runOp(5'h02, 16'h1234, 16'h0001, 16'h0); expectOp("R1 add plain", 16'h1235, 1, 16'h0000, 1, 0, 2);
    runOp(5'h03, 16'h0001, 16'h0002, 16'h0); expectOp("R2 sub borrow", 16'hFFFF, 1, 16'hFFFF, 1, 0, 2);
    runOp(5'h03, 16'h0005, 16'h0003, 16'h0); expectOp("R2 sub plain", 16'h0002, 1, 16'h0000, 1, 0, 2);
  endtask

  task automatic testMul();
    runOp(5'h04, 16'h1000, 16'h0100, 16'h0); expectOp("R3 mulu", 16'h0000, 1, 16'h0010, 1, 0, 2);
    runOp(5'h05, 16'hFFFE, 16'h0003, 16'h0); expectOp("R3 muls", 16'hFFFA, 1, 16'hFFFF, 1, 0, 2);
  endtask

  task automatic testDiv();
    runOp(5'h06, 16'h0007, 16'h0002, 16'h0); expectOp("R4 divu", 16'h0003, 1, 16'h8000, 1, 0, 3);
    runOp(5'h06, 16'h0007, 16'h0000, 16'h5); expectOp("R4 divu zero", 16'h0000, 1, 16'h0000, 1, 0, 3);
    runOp(5'h07, 16'hFFF9, 16'h0002, 16'h0); expectOp("R4 divs neg", 16'hFFFD, 1, 16'h8000, 1, 0, 3);
    runOp(5'h07, 16'hFFF9, 16'h0000, 16'h0); expectOp("R4 divs zero", 16'h0000, 1, 16'h0000, 1, 0, 3);
  endtask

  task automatic testRem();
    runOp(5'h08, 16'h0007, 16'h0003, 16'h0); expectOp("R5 remu", 16'h0001, 1, 16'h0, 0, 0, 3);
    runOp(5'h09, 16'hFFF9, 16'h0003, 16'h0); expectOp("R5 rems", 16'hFFFF, 1, 16'h0, 0, 0, 3);
    runOp(5'h08, 16'h0007, 16'h0000, 16'h0); expectOp("R5 rem zero", 16'h0000, 1, 16'h0, 0, 0, 3);
  endtask

  task automatic testCarry();
    runOp(5'h1A, 16'hFFFF, 16'h0000, 16'h0001); expectOp("R6 addc wrap", 16'h0000, 1, 16'h0001, 1, 0, 3);
    runOp(5'h1A, 16'h0001, 16'h0002, 16'h0003); expectOp("R6 addc word", 16'h0006, 1, 16'h0000, 1, 0, 3);
    runOp(5'h1B, 16'h0001, 16'h0003, 16'h0001); expectOp("R6 subc neg", 16'hFFFF, 1, 16'hFFFF, 1, 0, 3);
    runOp(5'h1B, 16'h0005, 16'h0003, 16'hFFFF); expectOp("R6 subc pos", 16'h0001, 1, 16'h0000, 1, 0, 3);
  endtask

  task automatic testLogic();
    runOp(5'h0A, 16'hF0F0, 16'hFF00, 16'h0); expectOp("R7 and", 16'hF000, 1, 16'h0, 0, 0, 1);
    runOp(5'h0B, 16'hF0F0, 16'hFF00, 16'h0); expectOp("R7 or", 16'hFFF0, 1, 16'h0, 0, 0, 1);
    runOp(5'h0C, 16'hF0F0, 16'hFF00, 16'h0); expectOp("R7 xor", 16'h0FF0, 1, 16'h0, 0, 0, 1);
  endtask

  task automatic testShift();
    runOp(5'h0F, 16'h8001, 16'd1, 16'h0);  expectOp("R8 sll 1", 16'h0002, 1, 16'h0001, 1, 0, 2);
    runOp(5'h0F, 16'h0001, 16'd20, 16'h0); expectOp("R8 sll 20", 16'h0000, 1, 16'h0010, 1, 0, 2);
    runOp(5'h0D, 16'h8001, 16'd1, 16'h0);  expectOp("R8 srl 1", 16'h4000, 1, 16'h8000, 1, 0, 2);
    runOp(5'h0D, 16'h8001, 16'd16, 16'h0); expectOp("R8 srl 16", 16'h0000, 1, 16'h8001, 1, 0, 2);
    runOp(5'h0E, 16'h8001, 16'd1, 16'h0);  expectOp("R8 sra 1", 16'hC000, 1, 16'h8000, 1, 0, 2);
    runOp(5'h0E, 16'h8000, 16'd20, 16'h0); expectOp("R8 sra 20", 16'hFFFF, 1, 16'hF800, 1, 0, 2);
  endtask

  task automatic testCompare();
    runOp(5'h12, 16'd5, 16'd5, 16'h0);       expectOp("R9 eq pass", 16'h0, 0, 16'h0, 0, 0, 2);
    runOp(5'h12, 16'd5, 16'd6, 16'h0);       expectOp("R9 eq fail", 16'h0, 0, 16'h0, 0, 1, 3);
    runOp(5'h13, 16'd1, 16'd2, 16'h0);       expectOp("R9 ne pass", 16'h0, 0, 16'h0, 0, 0, 2);
    runOp(5'h14, 16'hFFFF, 16'd1, 16'h0);    expectOp("R9 gtu pass", 16'h0, 0, 16'h0, 0, 0, 2);
    runOp(5'h15, 16'hFFFF, 16'd1, 16'h0);    expectOp("R9 gts fail", 16'h0, 0, 16'h0, 0, 1, 3);
    runOp(5'h16, 16'hFFFF, 16'd1, 16'h0);    expectOp("R9 ltu fail", 16'h0, 0, 16'h0, 0, 1, 3);
    runOp(5'h17, 16'hFFFF, 16'd1, 16'h0);    expectOp("R9 lts pass", 16'h0, 0, 16'h0, 0, 0, 2);
    runOp(5'h10, 16'h000F, 16'h0010, 16'h0); expectOp("R9 any fail", 16'h0, 0, 16'h0, 0, 1, 3);
    runOp(5'h11, 16'h000F, 16'h0010, 16'h0); expectOp("R9 none pass", 16'h0, 0, 16'h0, 0, 0, 2);
  endtask

  task automatic testOther();
    runOp(5'h01, 16'hABCD, 16'h1111, 16'h2222); expectOp("R10 pass-through", 16'hABCD, 1, 16'h0, 0, 0, 1);
    runOp(5'h18, 16'h0042, 16'h0001, 16'h0);    expectOp("R10 unlisted", 16'h0042, 1, 16'h0, 0, 0, 1);
  endtask

  task automatic testIdle();
    runOp(5'h12, 16'd5, 16'd6, 16'h0);
    @(negedge clk);
    chk("R11 idle valid", 32'(resValid), 0);
    chk("R11 idle skip", 32'(skipReq), 0);
    chk("R11 idle cost", 32'(cycleCost), 0);
    chk("R11 idle exWe", 32'(exWe), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testAddSub();
    testMul();
    testDiv();
    testRem();
    testCarry();
    testLogic();
    testShift();
    testCompare();
    testOther();
    testIdle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule